// File: doc/BRIEF.md
# Address reservation unit for atomic read-modify-write

This block holds one address reservation for each core of a small cluster and decides, in the same cycle a store arrives, whether that store may reach memory. The decoder flags an atomic sequence with two single-cycle prefix strobes instead of separate opcodes. A reserve prefix arms the core so that its next memory operation, load or store, records the long-word it touches as reserved. A conditional prefix arms the core so that its next store becomes conditional. That store is written only while the core still holds a valid reservation on the same long-word. It then reports success or failure on a carry-flag write port.

A reservation is lost when any other core commits a store to the reserved long-word, when an agent outside the cluster reports a write to it on the snoop port, when the owning core takes an exception, or on reset. A successful conditional store also consumes it. Stores issued in the same cycle are ordered by core index, with the snoop port treated as earliest. When two cores race for one semaphore, at most one of them succeeds.

Top module: `rsv_unit`

## Requirements
- R1: A reserve prefix followed by a load or a store (op_kind 2'b01 or 2'b10) records that operation's long-word as reserved. A reserve-prefixed store is itself written normally (st_en=1, cf_we=0).
- R2: A store (op_kind 2'b10) issued while a conditional prefix is armed raises cf_we. It sets st_en=1 and cf_val=1 only if the core's reservation is valid and on the same long-word. Otherwise st_en=0 and cf_val=0, and a reservation on a different long-word stays valid.
- R3: A successful conditional store clears the reservation, so an immediate second conditional store to the same address fails.
- R4: An armed prefix applies only to the next operation with op_valid=1 of that core, whatever its kind, and is then dropped. A prefix strobe replaces any prefix still armed.
- R5: Addresses are compared with their two low bits ignored (long-word granularity, GRAN_BITS=2).
- R6: A store committed by another core (st_en of that core) to the reserved long-word invalidates the reservation. A store to another long-word, or by the owning core without a prefix, does not.
- R7: snp_valid with snp_addr in the reserved long-word invalidates the reservation. A snoop to another long-word does not.
- R8: Reset and a one-cycle exc strobe clear the core's reservation and its armed prefix.
- R9: A plain store always gives st_en=1 and cf_we=0. Loads, op_kind 2'b00 and op_kind 2'b11 never raise st_en. A conditional prefix on a load gives no carry write.
- R10: Same-cycle ordering: a snoop or a store request from a lower-numbered core to the reserved long-word makes a conditional store fail. A same-cycle invalidation wins over a reservation being recorded on that long-word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pfx_rsv | input | NCORE | Per core: reserve prefix decoded this cycle |
| pfx_cond | input | NCORE | Per core: conditional-store prefix decoded this cycle |
| op_valid | input | NCORE | Per core: an instruction issues this cycle |
| op_kind | input | 2*NCORE | Per core kind: 00 other, 01 load, 10 store, 11 other |
| op_addr | input | AW*NCORE | Per core byte address of the operation |
| exc | input | NCORE | Per core: exception taken |
| snp_valid | input | 1 | External write observed |
| snp_addr | input | AW | Address of the external write |
| st_en | output | NCORE | Per core: store may be written to memory |
| cf_we | output | NCORE | Per core: write the carry flag |
| cf_val | output | NCORE | Per core: carry value, 1 on success |

## Verification
Random traffic runs over a pool of three long-words with random low address bits. This puts reserves, conditional stores, foreign stores and snoops on the same line often, so a long-word compare is told apart from a byte compare and from a wrong line. Directed races put two cores on one semaphore in one cycle, and a snoop or a foreign store in the cycle of a reservation or a conditional store. These separate the index ordering from an unordered design that would let both cores succeed. Sequences with prefixes followed by non-memory operations, by exceptions and by a second prefix show whether the armed state is dropped, cleared and replaced as required.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
   typedef enum logic [1:0] {
      OP_OTHER = 2'b00,
      OP_LOAD  = 2'b01,
      OP_STORE = 2'b10,
      OP_SPARE = 2'b11
   } op_kind_e;
endpackage

// File: rtl/rsv_lw_cmp.sv
// Long-word address comparator: low GRAN_BITS are ignored.
module rsv_lw_cmp #(
   parameter int AW        = 32,
   parameter int GRAN_BITS = 2
) (
   input  logic          en,
   input  logic [AW-1:0] a,
   input  logic [AW-1:0] b,
   output logic          hit
);
   localparam int TAG_W = AW - GRAN_BITS;
   logic [TAG_W-1:0] tag_a, tag_b;
   assign tag_a = a[AW-1:GRAN_BITS];
   assign tag_b = b[AW-1:GRAN_BITS];
   assign hit   = en && (tag_a == tag_b);
endmodule

// File: rtl/rsv_slot.sv
// One core's reservation register, armed prefix and store decision.
module rsv_slot
   import rsv_pkg::*;
#(
   parameter int AW        = 32,
   parameter int GRAN_BITS = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pfx_rsv,
   input  logic          pfx_cond,
   input  logic          op_valid,
   input  logic [1:0]    op_kind,
   input  logic [AW-1:0] op_addr,
   input  logic          exc,
   input  logic          hit_before,   // earlier same-cycle write to reserved line
   input  logic          kill_cur,     // other write to reserved line
   input  logic          kill_new,     // other write to the line being reserved
   output logic          st_req,
   output logic          st_en,
   output logic          cf_we,
   output logic          cf_val,
   output logic          res_valid,
   output logic [AW-1:0] res_addr
);
   logic arm_rsv, arm_cond;
   logic is_ld, own_hit, sc_ok, do_set;

   assign st_req = op_valid && (op_kind_e'(op_kind) == OP_STORE);
   assign is_ld  = op_valid && (op_kind_e'(op_kind) == OP_LOAD);

   rsv_lw_cmp #(.AW(AW), .GRAN_BITS(GRAN_BITS)) u_own (
      .en (res_valid),
      .a  (op_addr),
      .b  (res_addr),
      .hit(own_hit)
   );

   assign sc_ok  = arm_cond && st_req && own_hit && !hit_before;
   assign st_en  = st_req && (!arm_cond || sc_ok);
   assign cf_we  = st_req && arm_cond;
   assign cf_val = sc_ok;
   assign do_set = arm_rsv && (st_req || is_ld);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_addr  <= '0;
      end else if (exc) begin
         res_valid <= 1'b0;
      end else if (do_set) begin
         res_valid <= !kill_new;
         res_addr  <= op_addr;
      end else if (kill_cur || sc_ok) begin
         res_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_rsv  <= 1'b0;
         arm_cond <= 1'b0;
      end else if (exc) begin
         arm_rsv  <= 1'b0;
         arm_cond <= 1'b0;
      end else if (pfx_cond) begin
         arm_rsv  <= 1'b0;
         arm_cond <= 1'b1;
      end else if (pfx_rsv) begin
         arm_rsv  <= 1'b1;
         arm_cond <= 1'b0;
      end else if (op_valid) begin
         arm_rsv  <= 1'b0;
         arm_cond <= 1'b0;
      end
   end
endmodule

// File: rtl/rsv_unit.sv
// Reservation unit for NCORE cores with cross-core and external snooping.
module rsv_unit
   import rsv_pkg::*;
#(
   parameter int NCORE     = 4,
   parameter int AW        = 32,
   parameter int GRAN_BITS = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NCORE-1:0]      pfx_rsv,
   input  logic [NCORE-1:0]      pfx_cond,
   input  logic [NCORE-1:0]      op_valid,
   input  logic [2*NCORE-1:0]    op_kind,
   input  logic [AW*NCORE-1:0]   op_addr,
   input  logic [NCORE-1:0]      exc,
   input  logic                  snp_valid,
   input  logic [AW-1:0]         snp_addr,
   output logic [NCORE-1:0]      st_en,
   output logic [NCORE-1:0]      cf_we,
   output logic [NCORE-1:0]      cf_val
);
   localparam int KW = 2;

   if (NCORE < 1) begin : g_bad_ncore
      $error("rsv_unit: NCORE must be at least 1");
   end
   if (GRAN_BITS < 0 || GRAN_BITS >= AW) begin : g_bad_gran
      $error("rsv_unit: GRAN_BITS must lie in [0, AW)");
   end

   logic [NCORE-1:0]          st_req;
   logic [NCORE-1:0]          res_valid;
   logic [NCORE-1:0][AW-1:0]  res_addr;
   logic [NCORE-1:0][AW-1:0]  addr_c;
   logic [NCORE-1:0]          hit_before, kill_cur, kill_new;
   logic [NCORE-1:0]          snp_cur, snp_new;

   for (genvar c = 0; c < NCORE; c++) begin : g_addr
      assign addr_c[c] = op_addr[c*AW +: AW];
   end

   for (genvar i = 0; i < NCORE; i++) begin : g_core
      logic [NCORE-1:0] m_res;   // core j address vs reservation of core i
      logic [NCORE-1:0] m_new;   // core j address vs address core i reserves
      logic [NCORE-1:0] req_lower, com_other, com_new;

      rsv_lw_cmp #(.AW(AW), .GRAN_BITS(GRAN_BITS)) u_snp_cur (
         .en(snp_valid && res_valid[i]), .a(snp_addr), .b(res_addr[i]), .hit(snp_cur[i])
      );
      rsv_lw_cmp #(.AW(AW), .GRAN_BITS(GRAN_BITS)) u_snp_new (
         .en(snp_valid), .a(snp_addr), .b(addr_c[i]), .hit(snp_new[i])
      );

      for (genvar j = 0; j < NCORE; j++) begin : g_peer
         rsv_lw_cmp #(.AW(AW), .GRAN_BITS(GRAN_BITS)) u_res (
            .en(res_valid[i]), .a(addr_c[j]), .b(res_addr[i]), .hit(m_res[j])
         );
         rsv_lw_cmp #(.AW(AW), .GRAN_BITS(GRAN_BITS)) u_new (
            .en(1'b1), .a(addr_c[j]), .b(addr_c[i]), .hit(m_new[j])
         );
         if (j < i) begin : g_lower
            assign req_lower[j] = st_req[j] && m_res[j];
         end else begin : g_upper
            assign req_lower[j] = 1'b0;
         end
         if (j != i) begin : g_other
            assign com_other[j] = st_en[j] && m_res[j];
            assign com_new[j]   = st_en[j] && m_new[j];
         end else begin : g_self
            assign com_other[j] = 1'b0;
            assign com_new[j]   = 1'b0;
         end
      end

      assign hit_before[i] = snp_cur[i] || (|req_lower);
      assign kill_cur[i]   = snp_cur[i] || (|com_other);
      assign kill_new[i]   = snp_new[i] || (|com_new);

      rsv_slot #(.AW(AW), .GRAN_BITS(GRAN_BITS)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .pfx_rsv   (pfx_rsv[i]),
         .pfx_cond  (pfx_cond[i]),
         .op_valid  (op_valid[i]),
         .op_kind   (op_kind[i*KW +: KW]),
         .op_addr   (addr_c[i]),
         .exc       (exc[i]),
         .hit_before(hit_before[i]),
         .kill_cur  (kill_cur[i]),
         .kill_new  (kill_new[i]),
         .st_req    (st_req[i]),
         .st_en     (st_en[i]),
         .cf_we     (cf_we[i]),
         .cf_val    (cf_val[i]),
         .res_valid (res_valid[i]),
         .res_addr  (res_addr[i])
      );
   end
endmodule

// File: rtl/rsv_unit_chk.sv
// Port-level checker; keeps its own copy of the armed conditional prefix.
module rsv_unit_chk #(
   parameter int NCORE = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NCORE-1:0]     pfx_rsv,
   input logic [NCORE-1:0]     pfx_cond,
   input logic [NCORE-1:0]     op_valid,
   input logic [2*NCORE-1:0]   op_kind,
   input logic [NCORE-1:0]     exc,
   input logic [NCORE-1:0]     st_en,
   input logic [NCORE-1:0]     cf_we,
   input logic [NCORE-1:0]     cf_val
);
   for (genvar i = 0; i < NCORE; i++) begin : g_c
      logic cond_armed;
      logic is_store;
      assign is_store = op_valid[i] && (op_kind[2*i +: 2] == 2'b10);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            cond_armed <= 1'b0;
         else if (exc[i])       cond_armed <= 1'b0;
         else if (pfx_cond[i])  cond_armed <= 1'b1;
         else if (pfx_rsv[i])   cond_armed <= 1'b0;
         else if (op_valid[i])  cond_armed <= 1'b0;
      end

      assert_strobe_only_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
         st_en[i] |-> is_store);
      assert_plain_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (is_store && !cond_armed) |-> (st_en[i] && !cf_we[i]));
      assert_cond_reports_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (is_store && cond_armed) |-> (cf_we[i] && (cf_val[i] == st_en[i])));
      assert_carry_only_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
         cf_we[i] |-> cond_armed);
      assert_exc_drops_prefix_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (exc[i] && !pfx_cond[i]) |=> !cf_we[i]);
   end
endmodule

bind rsv_unit rsv_unit_chk #(.NCORE(NCORE)) u_rsv_chk (
   .clk(clk), .rst_n(rst_n), .pfx_rsv(pfx_rsv), .pfx_cond(pfx_cond),
   .op_valid(op_valid), .op_kind(op_kind), .exc(exc),
   .st_en(st_en), .cf_we(cf_we), .cf_val(cf_val)
);

// File: tb/test_rsv_unit.sv
module test_rsv_unit;
   localparam int NC  = 4;
   localparam int AW  = 32;
   localparam int CLK_PERIOD = 10;
   localparam int NRAND = 4000;
   localparam logic [AW-1:0] A = 32'h0000_1000;
   localparam logic [AW-1:0] B = 32'h0000_2000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic            d_pr [NC], d_pc [NC], d_ov [NC], d_exc [NC];
   logic [1:0]      d_kind [NC];
   logic [AW-1:0]   d_addr [NC];
   logic            d_sv;
   logic [AW-1:0]   d_sa;

   logic [NC-1:0]      pfx_rsv, pfx_cond, op_valid, exc, st_en, cf_we, cf_val;
   logic [2*NC-1:0]    op_kind;
   logic [AW*NC-1:0]   op_addr;

   always_comb begin
      for (int i = 0; i < NC; i++) begin
         pfx_rsv[i]  = d_pr[i];
         pfx_cond[i] = d_pc[i];
         op_valid[i] = d_ov[i];
         exc[i]      = d_exc[i];
         op_kind[2*i +: 2]  = d_kind[i];
         op_addr[AW*i +: AW] = d_addr[i];
      end
   end

   rsv_unit #(.NCORE(NC), .AW(AW), .GRAN_BITS(2)) i_rsv_unit (
      .clk(clk), .rst_n(rst_n), .pfx_rsv(pfx_rsv), .pfx_cond(pfx_cond),
      .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr), .exc(exc),
      .snp_valid(d_sv), .snp_addr(d_sa), .st_en(st_en), .cf_we(cf_we), .cf_val(cf_val)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference state
   logic          m_rv [NC], m_pr [NC], m_pc [NC];
   logic [AW-1:0] m_ra [NC];

   function automatic logic lw(input logic [AW-1:0] a, input logic [AW-1:0] b);
      return a[AW-1:2] == b[AW-1:2];
   endfunction

   task automatic chk(input string tag, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0b expected %0b", tag, got, exp);
      end
   endtask

   task automatic clear_in();
      for (int i = 0; i < NC; i++) begin
         d_pr[i] = 0; d_pc[i] = 0; d_ov[i] = 0; d_exc[i] = 0;
         d_kind[i] = 2'b00; d_addr[i] = '0;
      end
      d_sv = 0; d_sa = '0;
   endtask

   // Compare against the reference, cross the edge, update the reference.
   task automatic tick(input string tag);
      logic est [NC], ewe [NC], ecv [NC], isst [NC], isld [NC];
      logic nrv [NC], npr [NC], npc [NC];
      logic [AW-1:0] nra [NC];
      for (int i = 0; i < NC; i++) begin
         isst[i] = d_ov[i] && d_kind[i] == 2'b10;
         isld[i] = d_ov[i] && d_kind[i] == 2'b01;
      end
      for (int i = 0; i < NC; i++) begin
         logic hb;
         hb = d_sv && m_rv[i] && lw(d_sa, m_ra[i]);
         for (int j = 0; j < i; j++)
            if (isst[j] && m_rv[i] && lw(d_addr[j], m_ra[i])) hb = 1;
         ecv[i] = m_pc[i] && isst[i] && m_rv[i] && lw(d_addr[i], m_ra[i]) && !hb;
         est[i] = isst[i] && (!m_pc[i] || ecv[i]);
         ewe[i] = isst[i] && m_pc[i];
      end
      for (int i = 0; i < NC; i++) begin
         nrv[i] = m_rv[i]; nra[i] = m_ra[i];
         if (m_pr[i] && (isst[i] || isld[i])) begin
            logic kn;
            kn = d_sv && lw(d_sa, d_addr[i]);
            for (int j = 0; j < NC; j++)
               if (j != i && est[j] && lw(d_addr[j], d_addr[i])) kn = 1;
            nrv[i] = !kn; nra[i] = d_addr[i];
         end else begin
            logic kc;
            kc = d_sv && m_rv[i] && lw(d_sa, m_ra[i]);
            for (int j = 0; j < NC; j++)
               if (j != i && est[j] && m_rv[i] && lw(d_addr[j], m_ra[i])) kc = 1;
            if (kc || ecv[i]) nrv[i] = 0;
         end
         if (d_pc[i])       begin npr[i] = 0; npc[i] = 1; end
         else if (d_pr[i])  begin npr[i] = 1; npc[i] = 0; end
         else if (d_ov[i])  begin npr[i] = 0; npc[i] = 0; end
         else               begin npr[i] = m_pr[i]; npc[i] = m_pc[i]; end
         if (d_exc[i]) begin nrv[i] = 0; npr[i] = 0; npc[i] = 0; end
      end
      #1;
      for (int i = 0; i < NC; i++) begin
         chk($sformatf("%s model st_en core%0d", tag, i), st_en[i], est[i]);
         chk($sformatf("%s model cf_we core%0d", tag, i), cf_we[i], ewe[i]);
         chk($sformatf("%s model cf_val core%0d", tag, i), cf_val[i], ecv[i]);
      end
      @(posedge clk);
      for (int i = 0; i < NC; i++) begin
         m_rv[i] = nrv[i]; m_ra[i] = nra[i]; m_pr[i] = npr[i]; m_pc[i] = npc[i];
      end
      @(negedge clk);
      clear_in();
   endtask

   task automatic op(input int c, input logic [1:0] k, input logic [AW-1:0] a);
      d_ov[c] = 1; d_kind[c] = k; d_addr[c] = a;
   endtask

   task automatic reserve(input int c, input logic [AW-1:0] a, input string tag);
      d_pr[c] = 1; tick(tag);
      op(c, 2'b01, a); tick(tag);
   endtask

   // conditional store with hand-computed expectation
   task automatic sc(input int c, input logic [AW-1:0] a, input logic ok, input string tag);
      d_pc[c] = 1; tick(tag);
      op(c, 2'b10, a);
      #1;
      chk({tag, " sc st_en"}, st_en[c], ok);
      chk({tag, " sc cf_we"}, cf_we[c], 1'b1);
      chk({tag, " sc cf_val"}, cf_val[c], ok);
      tick(tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      clear_in();
      for (int i = 0; i < NC; i++) begin m_rv[i] = 0; m_pr[i] = 0; m_pc[i] = 0; m_ra[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      chk("R8 reset st_en", |st_en, 1'b0);
      chk("R8 reset cf_we", |cf_we, 1'b0);
      @(negedge clk);

      sc(0, A, 0, "R8 no reservation after reset");
      // R1 / R5: load reserve, store at another byte of the long-word
      reserve(0, A, "R1 reserve");
      sc(0, A | 32'h2, 1, "R1 R5 byte offset");
      sc(0, A, 0, "R3 second sc");
      // R1 via reserve-prefixed store
      d_pr[0] = 1; tick("R1 pfx");
      op(0, 2'b10, B); #1;
      chk("R1 reserve store st_en", st_en[0], 1'b1);
      chk("R1 reserve store cf_we", cf_we[0], 1'b0);
      tick("R1 store");
      sc(0, B | 32'h3, 1, "R1 R5 store reserve");
      // R6
      reserve(0, A, "R6 r");
      op(1, 2'b10, A + 4); tick("R6 other line");
      sc(0, A, 1, "R6 other line keeps");
      reserve(0, A, "R6 r2");
      op(1, 2'b10, A + 1); tick("R6 same line");
      sc(0, A, 0, "R6 foreign store kills");
      reserve(0, A, "R6 r3");
      op(0, 2'b10, A); tick("R6 own plain store");
      sc(0, A, 1, "R6 own store keeps");
      // R7
      reserve(0, A, "R7 r");
      d_sv = 1; d_sa = A + 3; tick("R7 snoop hit");
      sc(0, A, 0, "R7 snoop kills");
      reserve(0, A, "R7 r2");
      d_sv = 1; d_sa = B; tick("R7 snoop miss");
      sc(0, A, 1, "R7 snoop other line keeps");
      // R8 exception
      reserve(0, A, "R8 r");
      d_exc[0] = 1; tick("R8 exc");
      sc(0, A, 0, "R8 exc clears");
      d_pc[0] = 1; tick("R8 pfx");
      d_exc[0] = 1; tick("R8 exc2");
      op(0, 2'b10, A); #1;
      chk("R8 exc drops prefix cf_we", cf_we[0], 1'b0);
      chk("R8 exc drops prefix st_en", st_en[0], 1'b1);
      tick("R8 st");
      // R4
      d_pr[0] = 1; tick("R4 pfx");
      op(0, 2'b00, A); tick("R4 other op");
      op(0, 2'b01, A); tick("R4 plain load");
      sc(0, A, 0, "R4 prefix consumed by other op");
      d_pc[0] = 1; tick("R4 cond"); d_pr[0] = 1; tick("R4 replace");
      op(0, 2'b01, A); tick("R4 load");
      sc(0, A, 1, "R4 later prefix replaces");
      // R9
      d_pc[0] = 1; tick("R9 pfx");
      op(0, 2'b01, A); #1;
      chk("R9 cond load st_en", st_en[0], 1'b0);
      chk("R9 cond load cf_we", cf_we[0], 1'b0);
      tick("R9 load");
      op(0, 2'b11, A); #1;
      chk("R9 spare kind st_en", st_en[0], 1'b0);
      tick("R9 spare");
      // R2 mismatch keeps reservation
      reserve(0, A, "R2 r");
      sc(0, B, 0, "R2 mismatch fails");
      sc(0, A, 1, "R2 reservation kept after mismatch");
      // R10 races
      d_pr[0] = 1; d_pr[1] = 1; tick("R10 pfx");
      op(0, 2'b01, A); op(1, 2'b01, A); tick("R10 loads");
      d_pc[0] = 1; d_pc[1] = 1; tick("R10 cond");
      op(0, 2'b10, A); op(1, 2'b10, A); #1;
      chk("R10 race core0 wins", cf_val[0], 1'b1);
      chk("R10 race core1 loses", cf_val[1], 1'b0);
      chk("R10 race core1 no strobe", st_en[1], 1'b0);
      tick("R10 race");
      d_pr[0] = 1; tick("R10 pfx2");
      op(0, 2'b01, A); op(1, 2'b10, A); tick("R10 set vs kill");
      sc(0, A, 0, "R10 kill beats set");
      reserve(0, A, "R10 r3");
      d_pc[0] = 1; tick("R10 cond3");
      op(0, 2'b10, A); d_sv = 1; d_sa = A; #1;
      chk("R10 snoop same cycle", cf_val[0], 1'b0);
      tick("R10 snoop sc");

      // constrained random against the reference
      void'($urandom(32'd1234));
      for (int n = 0; n < NRAND; n++) begin
         for (int i = 0; i < NC; i++) begin
            int r;
            r = $urandom % 16;
            if (r < 3) d_pr[i] = 1;
            else if (r < 6) d_pc[i] = 1;
            if ($urandom % 2 == 0) begin
               d_ov[i] = 1;
               d_kind[i] = 2'($urandom % 4);
               d_addr[i] = 32'h100 + 32'(($urandom % 3) * 4) + 32'($urandom % 4);
            end
            if ($urandom % 64 == 0) d_exc[i] = 1;
         end
         if ($urandom % 16 == 0) begin
            d_sv = 1; d_sa = 32'h100 + 32'(($urandom % 3) * 4) + 32'($urandom % 4);
         end
         tick("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule